// File: doc/BRIEF.md
# Status Register and Write-Protection Guard for a Serial EEPROM

This block keeps the status byte of a serial EEPROM and rules, cycle by cycle, whether a write may start. The serial shifter upstream decodes instructions and delivers them as one-cycle strobes: set-enable, clear-enable, status-register write (with its data byte), an array-write request (with a target byte address) and a write-complete strobe from the self-timed write engine. The guard answers an array-write request or a status-register write in the same cycle with a go pulse, which the write engine uses to begin its cycle.

Two independent mechanisms refuse writes. A two-bit region code selects a protected part of the array: nothing, the top quarter, the top half or all of it. A write-protect pin, low-active, locks the status register whenever the stored pin-enable bit is 1. All writes also need the write-enable latch, which is set by a set-enable strobe and cleared by a clear-enable strobe, by reset, or at the end of every write attempt.

A three-state machine drives the block. In IDLE it accepts strobes. The transition IDLE to ARRAY_WRITE is taken by an accepted array write, and IDLE to STATUS_WRITE by an accepted status-register write. ARRAY_WRITE to IDLE and STATUS_WRITE to IDLE are taken on the write-complete strobe; the second one also loads the pending status data. All other strobes leave the state where it is.

Top module: `eeprom_status_guard`

## Requirements
- R1: After reset the status byte reads 0x00 and both go outputs are 0.
- R2: Status byte layout: bit 0 = write in progress, bit 1 = write-enable latch, bits 3:2 = region code (bit 3 high bit), bit 7 = pin-enable bit; bits 6:4 always read 0, and a status write stores only bits 7, 3 and 2 of its data.
- R3: In IDLE a set-enable strobe makes bit 1 read 1 from the next cycle; a clear-enable strobe makes it read 0 from the next cycle.
- R4: An array-write request gives `arr_go_o`=1 in the same cycle only in IDLE with the latch set and an unprotected address; bit 0 then reads 1 from the next cycle.
- R5: Region code 00 protects no address; 01 protects addresses whose two top bits are 11 (0x1800-0x1FFF); 10 protects those whose top bit is 1 (0x1000-0x1FFF); 11 protects every address.
- R6: A request with the latch set to a protected address gives `arr_go_o`=0, leaves bit 0 at 0 and clears the latch next cycle.
- R7: A status write is accepted (`sr_go_o`=1, same cycle) only in IDLE with the latch set and no pin lock; pin lock means pin low and pin-enable bit 1. The new bits 7, 3:2 appear only after the write-complete strobe.
- R8: A refused status write changes no status bit, the latch included.
- R9: While bit 0 reads 1, every strobe except write-complete is ignored and both go outputs stay 0.
- R10: A write-complete strobe while busy makes bits 0 and 1 read 0 from the next cycle; in IDLE it has no effect.
- R11: When several strobes arrive together in IDLE only the first in the order clear-enable, set-enable, status write, array write acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wren_i | input | 1 | Set-enable strobe |
| wrdi_i | input | 1 | Clear-enable strobe |
| wrsr_i | input | 1 | Status-register write strobe |
| wrsr_data_i | input | 8 | Data byte for a status-register write |
| arr_req_i | input | 1 | Array-write request strobe |
| arr_addr_i | input | ADDR_W | Byte address of the array-write request |
| done_i | input | 1 | Write-complete strobe from the write engine |
| guard_pin_n_i | input | 1 | Write-protect pin level, low means lock |
| status_o | output | 8 | Status byte |
| arr_go_o | output | 1 | Array write allowed, one-cycle pulse |
| sr_go_o | output | 1 | Status write allowed, one-cycle pulse |

## Verification
Array requests are tried at the addresses on both sides of every region boundary under each region code, so an off-by-one compare or a swapped code is told apart from a correct map. Status writes are tried under the four combinations of pin level and pin-enable bit, separating the lock from the latch check, and strobes are repeated while each busy state holds to show they are ignored. Simultaneous strobe pairs expose the priority order, and a status write with all data bits set shows which bits are stored.

// File: rtl/esg_pkg.sv
package esg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE         = 2'd0,
        ST_ARRAY_WRITE  = 2'd1,
        ST_STATUS_WRITE = 2'd2
    } esg_state_e;

    typedef enum logic [1:0] {
        REGION_NONE    = 2'b00,
        REGION_QUARTER = 2'b01,
        REGION_HALF    = 2'b10,
        REGION_ALL     = 2'b11
    } region_code_e;

    localparam int STAT_W      = 8;
    localparam int BIT_BUSY    = 0;
    localparam int BIT_WEL     = 1;
    localparam int BIT_REG_LO  = 2;
    localparam int BIT_REG_HI  = 3;
    localparam int BIT_PIN_EN  = 7;

endpackage

// File: rtl/esg_region_check.sv
module esg_region_check
    import esg_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  region_code_e      code_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              locked_o
);
    localparam int TOP = ADDR_W - 1;

    always_comb begin
        unique case (code_i)
            REGION_NONE:    locked_o = 1'b0;
            REGION_QUARTER: locked_o = addr_i[TOP] & addr_i[TOP-1];
            REGION_HALF:    locked_o = addr_i[TOP];
            REGION_ALL:     locked_o = 1'b1;
            default:        locked_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/esg_ctrl_fsm.sv
module esg_ctrl_fsm
    import esg_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wren_i,
    input  logic         wrdi_i,
    input  logic         wrsr_i,
    input  logic [STAT_W-1:0] wrsr_data_i,
    input  logic         arr_req_i,
    input  logic         region_locked_i,
    input  logic         done_i,
    input  logic         guard_pin_n_i,
    output esg_state_e   state_o,
    output logic         wel_o,
    output region_code_e region_o,
    output logic         pin_en_o,
    output logic         arr_go_o,
    output logic         sr_go_o
);
    esg_state_e   state_q, state_d;
    logic         wel_q, wel_d;
    region_code_e region_q, pend_region_q;
    logic         pin_en_q, pend_pin_en_q;
    logic         commit;
    logic         hw_lock;

    assign hw_lock = pin_en_q & ~guard_pin_n_i;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wel_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            wel_q   <= wel_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d  = state_q;
        wel_d    = wel_q;
        arr_go_o = 1'b0;
        sr_go_o  = 1'b0;
        commit   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (wrdi_i) begin
                    wel_d = 1'b0;
                end else if (wren_i) begin
                    wel_d = 1'b1;
                end else if (wrsr_i) begin
                    if (wel_q && !hw_lock) begin
                        sr_go_o = 1'b1;
                        state_d = ST_STATUS_WRITE;
                    end
                end else if (arr_req_i && wel_q) begin
                    if (region_locked_i) begin
                        wel_d = 1'b0;
                    end else begin
                        arr_go_o = 1'b1;
                        state_d  = ST_ARRAY_WRITE;
                    end
                end
            end
            ST_ARRAY_WRITE: begin
                if (done_i) begin
                    state_d = ST_IDLE;
                    wel_d   = 1'b0;
                end
            end
            ST_STATUS_WRITE: begin
                if (done_i) begin
                    state_d = ST_IDLE;
                    wel_d   = 1'b0;
                    commit  = 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                wel_d   = 1'b0;
            end
        endcase
    end

    // Configuration bits: captured on acceptance, applied on completion
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            region_q      <= REGION_NONE;
            pin_en_q      <= 1'b0;
            pend_region_q <= REGION_NONE;
            pend_pin_en_q <= 1'b0;
        end else begin
            if (sr_go_o) begin
                pend_region_q <= region_code_e'(wrsr_data_i[BIT_REG_HI:BIT_REG_LO]);
                pend_pin_en_q <= wrsr_data_i[BIT_PIN_EN];
            end
            if (commit) begin
                region_q <= pend_region_q;
                pin_en_q <= pend_pin_en_q;
            end
        end
    end

    assign state_o  = state_q;
    assign wel_o    = wel_q;
    assign region_o = region_q;
    assign pin_en_o = pin_en_q;

    // R3
    wel_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && wren_i && !wrdi_i) |=> wel_q);

    // R3
    wel_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && wrdi_i) |=> !wel_q);

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !done_i) |=>
            (state_q == $past(state_q)) && $stable(wel_q) && $stable(region_q) && $stable(pin_en_q));

    // R10
    done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && done_i) |=> (state_q == ST_IDLE) && !wel_q);

    // R4
    arr_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_go_o |=> (state_q == ST_ARRAY_WRITE));

endmodule

// File: rtl/eeprom_status_guard.sv
module eeprom_status_guard
    import esg_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wren_i,
    input  logic              wrdi_i,
    input  logic              wrsr_i,
    input  logic [7:0]        wrsr_data_i,
    input  logic              arr_req_i,
    input  logic [ADDR_W-1:0] arr_addr_i,
    input  logic              done_i,
    input  logic              guard_pin_n_i,
    output logic [7:0]        status_o,
    output logic              arr_go_o,
    output logic              sr_go_o
);
    esg_state_e   state;
    logic         wel;
    region_code_e region;
    logic         pin_en;
    logic         locked;

    esg_region_check #(.ADDR_W(ADDR_W)) u_region (
        .code_i   (region),
        .addr_i   (arr_addr_i),
        .locked_o (locked)
    );

    esg_ctrl_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .wren_i          (wren_i),
        .wrdi_i          (wrdi_i),
        .wrsr_i          (wrsr_i),
        .wrsr_data_i     (wrsr_data_i),
        .arr_req_i       (arr_req_i),
        .region_locked_i (locked),
        .done_i          (done_i),
        .guard_pin_n_i   (guard_pin_n_i),
        .state_o         (state),
        .wel_o           (wel),
        .region_o        (region),
        .pin_en_o        (pin_en),
        .arr_go_o        (arr_go_o),
        .sr_go_o         (sr_go_o)
    );

    always_comb begin
        status_o                           = '0;
        status_o[BIT_BUSY]                 = (state != ST_IDLE);
        status_o[BIT_WEL]                  = wel;
        status_o[BIT_REG_HI:BIT_REG_LO]    = region;
        status_o[BIT_PIN_EN]               = pin_en;
    end

    // R6
    prot_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_req_i && locked) |-> !arr_go_o);

    // R7
    pin_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrsr_i && status_o[7] && !guard_pin_n_i) |-> !sr_go_o);

    // R9
    busy_nogo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[0] |-> !arr_go_o && !sr_go_o);

    // R11
    go_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({arr_go_o, sr_go_o}));

endmodule

// File: tb/tb_eeprom_status_guard.sv
module tb_eeprom_status_guard;
    localparam int AW = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wren = 1'b0, wrdi = 1'b0, wrsr = 1'b0, areq = 1'b0, done = 1'b0;
    logic [7:0]    wdata = '0;
    logic [AW-1:0] addr = '0;
    logic          pin_n = 1'b1;
    logic [7:0]    status;
    logic          arr_go, sr_go;
    logic          got_arr, got_sr;
    int            n_chk = 0;
    int            n_fail = 0;
    bit            finished = 1'b0;

    always #5 clk = ~clk;

    eeprom_status_guard #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n),
        .wren_i(wren), .wrdi_i(wrdi), .wrsr_i(wrsr), .wrsr_data_i(wdata),
        .arr_req_i(areq), .arr_addr_i(addr), .done_i(done),
        .guard_pin_n_i(pin_n),
        .status_o(status), .arr_go_o(arr_go), .sr_go_o(sr_go)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    // Drive one cycle of strobes, capture go outputs, then clear strobes after the edge
    task automatic issue(input logic e, input logic d, input logic s, input logic [7:0] dat,
                         input logic r, input logic [AW-1:0] a, input logic c);
        wren = e; wrdi = d; wrsr = s; wdata = dat; areq = r; addr = a; done = c;
        #1;
        got_arr = arr_go;
        got_sr  = sr_go;
        @(posedge clk); #1;
        wren = 0; wrdi = 0; wrsr = 0; areq = 0; done = 0;
    endtask

    task automatic set_sr(input logic [7:0] dat);
        issue(1, 0, 0, 8'h00, 0, '0, 0);
        issue(0, 0, 1, dat,   0, '0, 0);
        chk("R7 status write accepted", {7'd0, got_sr}, 8'h01);
        issue(0, 0, 0, 8'h00, 0, '0, 1);
    endtask

    task automatic try_array(input string tag, input logic [AW-1:0] a, input logic exp_go);
        issue(1, 0, 0, 8'h00, 0, '0, 0);
        issue(0, 0, 0, 8'h00, 1, a, 0);
        chk(tag, {7'd0, got_arr}, {7'd0, exp_go});
        if (exp_go) begin
            chk("R4 busy after accepted write", {7'd0, status[0]}, 8'h01);
            issue(0, 0, 0, 8'h00, 0, '0, 1);
        end else begin
            chk("R6 latch cleared, not busy", {6'd0, status[1:0]}, 8'h00);
        end
    endtask

    task automatic t_reset();
        chk("R1 status after reset", status, 8'h00);
        chk("R1 go outputs after reset", {6'd0, arr_go, sr_go}, 8'h00);
    endtask

    task automatic t_latch();
        issue(1, 0, 0, 8'h00, 0, '0, 0);
        chk("R3 set-enable", status, 8'h02);
        issue(0, 1, 0, 8'h00, 0, '0, 0);
        chk("R3 clear-enable", status, 8'h00);
        issue(0, 0, 0, 8'h00, 1, 13'h0000, 0);
        chk("R4 no go without latch", {7'd0, got_arr}, 8'h00);
        chk("R4 no busy without latch", status, 8'h00);
        issue(0, 0, 0, 8'h00, 0, '0, 1);
        chk("R10 done in idle ignored", status, 8'h00);
    endtask

    task automatic t_busy_ignore();
        issue(1, 0, 0, 8'h00, 0, '0, 0);
        issue(0, 0, 0, 8'h00, 1, 13'h1FFF, 0);
        chk("R4 go at top address, no region", {7'd0, got_arr}, 8'h01);
        chk("R4 status busy+latch", status, 8'h03);
        issue(0, 1, 0, 8'h00, 0, '0, 0);
        chk("R9 clear-enable ignored while busy", status, 8'h03);
        issue(0, 0, 1, 8'h8C, 1, 13'h0000, 0);
        chk("R9 no go while busy", {6'd0, got_arr, got_sr}, 8'h00);
        chk("R9 status unchanged while busy", status, 8'h03);
        issue(0, 0, 0, 8'h00, 0, '0, 1);
        chk("R10 done ends write", status, 8'h00);
    endtask

    task automatic t_regions();
        set_sr(8'h04);
        chk("R5 code 01 stored", status, 8'h04);
        try_array("R5 code 01 below quarter allowed", 13'h17FF, 1);
        try_array("R6 code 01 quarter start blocked", 13'h1800, 0);
        chk("R6 status after drop", status, 8'h04);
        set_sr(8'h08);
        try_array("R5 code 10 below half allowed", 13'h0FFF, 1);
        try_array("R6 code 10 half start blocked", 13'h1000, 0);
        set_sr(8'h0C);
        try_array("R5 code 11 address 0 blocked", 13'h0000, 0);
        try_array("R5 code 11 top blocked", 13'h1FFF, 0);
        set_sr(8'h00);
        try_array("R5 code 00 address 0 allowed", 13'h0000, 1);
    endtask

    task automatic t_pin_lock();
        set_sr(8'hFF);
        chk("R2 only bits 7,3,2 stored", status, 8'h8C);
        set_sr(8'h80);
        chk("R2 pin-enable bit", status, 8'h80);
        pin_n = 1'b0;
        issue(1, 0, 0, 8'h00, 0, '0, 0);
        issue(0, 0, 1, 8'h0C, 0, '0, 0);
        chk("R7 locked status write refused", {7'd0, got_sr}, 8'h00);
        chk("R8 refused write changes nothing", status, 8'h82);
        issue(0, 0, 0, 8'h00, 1, 13'h1FFF, 0);
        chk("R4 array write not affected by pin", {7'd0, got_arr}, 8'h01);
        issue(0, 0, 0, 8'h00, 0, '0, 1);
        pin_n = 1'b1;
        set_sr(8'h00);
        chk("R7 pin high unlocks", status, 8'h00);
        pin_n = 1'b0;
        issue(1, 0, 0, 8'h00, 0, '0, 0);
        issue(0, 0, 1, 8'h0C, 0, '0, 0);
        chk("R7 pin low, enable 0 accepted", {7'd0, got_sr}, 8'h01);
        chk("R7 new bits not applied before done", status, 8'h03);
        issue(0, 0, 0, 8'h00, 0, '0, 1);
        chk("R7 new bits applied after done", status, 8'h0C);
        pin_n = 1'b1;
        set_sr(8'h00);
    endtask

    task automatic t_priority();
        issue(1, 1, 0, 8'h00, 0, '0, 0);
        chk("R11 clear-enable beats set-enable", status, 8'h00);
        issue(1, 0, 0, 8'h00, 1, 13'h0000, 0);
        chk("R11 set-enable beats array request", {7'd0, got_arr}, 8'h00);
        chk("R11 latch set, not busy", status, 8'h02);
        issue(0, 0, 1, 8'h0C, 1, 13'h0000, 0);
        chk("R11 status write beats array request", {6'd0, got_arr, got_sr}, 8'h01);
        issue(0, 0, 0, 8'h00, 0, '0, 1);
        chk("R11 status write completed", status, 8'h0C);
        set_sr(8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_latch();
        t_busy_ignore();
        t_regions();
        t_pin_lock();
        t_priority();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule